// File: doc/BRIEF.md
# Flash Completion Poll Controller

This block sits on the host side of a parallel NOR flash. It watches an embedded program or erase operation until that operation ends. After the command sequence has been written elsewhere, a start pulse hands the controller four values: the operation kind, the expected data byte and the poll address, plus a backstop limit on the number of polls. The controller then issues status reads through a request/acknowledge port.

The controller judges each status byte from two bits. The first is the completion bit, bit 7. During a program operation it reads inverted until the write finishes. During an erase it reads 1 once the erase is over. The second is the fault bit, bit 5, which reports that the flash's internal time limit has run out. A fault is never trusted on its own: the completion bit is re-read first. Once completion is seen, one more read is taken, because the other data bits may settle later than bit 7. That byte is returned with a one-cycle done pulse. A failed operation ends in a one-cycle error pulse.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, rd_req_o, done_o, error_o and busy_o are low and data_o is zero.
- R2: A start_i pulse is taken only while busy_o is low. A start_i pulse while busy changes neither the address being polled nor the outcome, nor does it add reads.
- R3: For a program operation (op_erase_i = 0), a status byte is complete when its bit 7 equals bit 7 of exp_data_i.
- R4: For an erase operation (op_erase_i = 1), a status byte is complete when its bit 7 is 1, whatever exp_data_i holds.
- R5: A status byte that is not complete but has bit 5 set causes exactly one recheck read. If that recheck byte is complete, the operation proceeds to success.
- R6: If the recheck byte is not complete, error_o pulses and no further read is issued.
- R7: After a complete byte, exactly one extra read is issued. data_o takes that read's byte, and done_o pulses in the cycle after its acknowledge.
- R8: With max_polls_i nonzero (sampled at start), the operation fails with error_o after that many consecutive polls that are neither complete nor have bit 5 set. A value of zero disables this limit.
- R9: rd_req_o stays high until rd_ack_i, and rd_addr_o always equals the poll_addr_i captured at start.
- R10: done_o and error_o are never high together. Each lasts one cycle, and busy_o is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (taken only when idle) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| exp_data_i | input | DW | Byte that was programmed |
| poll_addr_i | input | AW | Address to poll |
| max_polls_i | input | CW | Backstop poll limit, 0 = none |
| rd_req_o | output | 1 | Read request to flash bus |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle success pulse |
| error_o | output | 1 | One-cycle failure pulse |
| data_o | output | DW | Final valid byte |

## Verification
Several status sequences are played back, each through a bench flash responder with its own read latency. One program case matches on the first poll and another matches only after several busy polls. An erase case includes bytes whose bit 7 would pass a program check, which tells the erase rule apart from the program rule. Two cases set bit 5: in one the recheck passes and in the other it fails, which separates the recheck path from a plain timeout. Further cases reach the backstop limit, run well past it with the limit disabled, and issue a start while busy with a changed address, to show that start is ignored.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_RECHK = 2'd2,
    ST_FINAL = 2'd3
  } poll_state_e;
endpackage

// File: rtl/poll_status_eval.sv
module poll_status_eval (
  input  logic op_erase_i,
  input  logic exp_bit_i,
  input  logic st_done_bit_i,
  input  logic st_fault_bit_i,
  output logic complete_o,
  output logic fault_o
);
  // program: bit reads inverted until written; erase: bit reads 1 when done
  assign complete_o = op_erase_i ? st_done_bit_i : (st_done_bit_i == exp_bit_i);
  assign fault_o    = st_fault_bit_i;
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [CW-1:0] limit_i,
  input  logic          step_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = (limit_i != '0) && (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (step_i && !expire_o) cnt_q <= cnt_q + CW'(1);
  end

  p_budget_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i != '0 && !clear_i) |-> (cnt_q < limit_i));
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int CW        = 16,
  parameter int DONE_BIT  = 7,
  parameter int FAULT_BIT = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [AW-1:0] poll_addr_i,
  input  logic [CW-1:0] max_polls_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o,
  output logic [DW-1:0] data_o
);
  poll_state_e   state_q, state_d;
  logic          op_q, exp_bit_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] lim_q;
  logic [DW-1:0] data_q;
  logic          done_q, err_q, done_d, err_d;
  logic          complete, fault, expire, step, take;

  assign take = (state_q == ST_IDLE) && start_i;

  poll_status_eval u_eval (
    .op_erase_i     (op_q),
    .exp_bit_i      (exp_bit_q),
    .st_done_bit_i  (rd_data_i[DONE_BIT]),
    .st_fault_bit_i (rd_data_i[FAULT_BIT]),
    .complete_o     (complete),
    .fault_o        (fault)
  );

  assign step = (state_q == ST_POLL) && rd_ack_i && !complete && !fault;

  poll_budget #(.CW(CW)) u_budget (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (take),
    .limit_i  (lim_q),
    .step_i   (step),
    .expire_o (expire)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_POLL;
      ST_POLL:  if (rd_ack_i) begin
        if (complete)    state_d = ST_FINAL;
        else if (fault)  state_d = ST_RECHK;
        else if (expire) begin state_d = ST_IDLE; err_d = 1'b1; end
      end
      ST_RECHK: if (rd_ack_i) begin
        if (complete) state_d = ST_FINAL;
        else begin state_d = ST_IDLE; err_d = 1'b1; end
      end
      ST_FINAL: if (rd_ack_i) begin state_d = ST_IDLE; done_d = 1'b1; end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= 1'b0;
      exp_bit_q <= 1'b0;
      addr_q    <= '0;
      lim_q     <= '0;
      data_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (take) begin
        op_q      <= op_erase_i;
        exp_bit_q <= exp_data_i[DONE_BIT];
        addr_q    <= poll_addr_i;
        lim_q     <= max_polls_i;
      end
      if (state_q == ST_FINAL && rd_ack_i) data_q <= rd_data_i;
    end
  end

  assign rd_req_o  = (state_q != ST_IDLE);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign error_o   = err_q;
  assign data_o    = data_q;

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));
  p_start_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(rd_addr_o));
  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o);
  p_done_after_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rd_ack_i));
endmodule

// File: tb/tb_flash_poll_ctrl.sv
module tb_flash_poll_ctrl;
  localparam int AW = 19, DW = 8, CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, op_erase_i = 1'b0;
  logic [DW-1:0] exp_data_i = '0;
  logic [AW-1:0] poll_addr_i = '0;
  logic [CW-1:0] max_polls_i = '0;
  logic          rd_req_o, rd_ack_i = 1'b0;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i = '0;
  logic          busy_o, done_o, error_o;
  logic [DW-1:0] data_o;

  always #10 clk = ~clk;

  flash_poll_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .exp_data_i(exp_data_i), .poll_addr_i(poll_addr_i), .max_polls_i(max_polls_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
    .data_o(data_o)
  );

  int total = 0, bad = 0;
  logic [DW-1:0] resp_q[$];
  int served = 0, lat = 0, wait_cnt = 0;
  logic [AW-1:0] cur_addr = '0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // flash responder and per-clock address comparison
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (rd_req_o) chk(rd_addr_o == cur_addr, "R9", rd_addr_o, cur_addr);
      if (rd_ack_i) rd_ack_i = 1'b0;
      else if (rd_req_o) begin
        if (wait_cnt < lat) wait_cnt++;
        else begin
          wait_cnt = 0;
          rd_ack_i = 1'b1;
          rd_data_i = (resp_q.size() != 0) ? resp_q.pop_front() : 8'h00;
          served++;
        end
      end
    end
  end

  // behavioural expectation: outcome, reads used, final byte
  function automatic void predict(input bit erase, input logic [7:0] e, input int mx,
                                  input logic [7:0] q[$], output bit ok, output int nrd,
                                  output logic [7:0] fin);
    int idx = 0, polls = 0;
    logic [7:0] b;
    ok = 0; nrd = 0; fin = 0;
    while (idx < q.size()) begin
      b = q[idx]; idx++;
      if (erase ? b[7] : (b[7] == e[7])) begin
        fin = q[idx]; idx++; ok = 1; nrd = idx; return;
      end
      if (b[5]) begin
        b = q[idx]; idx++;
        if (erase ? b[7] : (b[7] == e[7])) begin
          fin = q[idx]; idx++; ok = 1; nrd = idx; return;
        end
        nrd = idx; return;
      end
      polls++;
      if (mx != 0 && polls == mx) begin nrd = idx; return; end
    end
    nrd = idx;
  endfunction

  task automatic run_op(input string req, input bit erase, input logic [7:0] e,
                        input logic [AW-1:0] a, input int mx, input int l,
                        input logic [7:0] q[$], input bit poke);
    bit ok; int nrd; logic [7:0] fin; int cyc = 0;
    predict(erase, e, mx, q, ok, nrd, fin);
    resp_q = q; served = 0; lat = l; wait_cnt = 0; cur_addr = a;
    @(negedge clk);
    start_i = 1; op_erase_i = erase; exp_data_i = e; poll_addr_i = a; max_polls_i = CW'(mx);
    @(negedge clk);
    start_i = 0; op_erase_i = ~erase; exp_data_i = ~e; max_polls_i = CW'(1);
    if (poke) fork
      begin
        repeat (4) @(negedge clk);
        start_i = 1; poll_addr_i = a ^ 19'h155; op_erase_i = 1;
        @(negedge clk);
        start_i = 0;
      end
    join_none
    while (!(done_o || error_o) && cyc < 500) begin @(negedge clk); cyc++; end
    chk(done_o == ok, {req, " done"}, done_o, ok);
    chk(error_o == !ok, {req, " error"}, error_o, !ok);
    chk(!busy_o, "R10 busy low at end", busy_o, 0);
    chk(served == nrd, {req, " reads"}, served, nrd);
    if (ok) chk(data_o == fin, "R7 data", data_o, fin);
    @(negedge clk);
    chk(!done_o && !error_o, "R10 one-cycle pulse", {done_o, error_o}, 0);
    repeat (3) @(negedge clk);
    chk(served == nrd && !rd_req_o, {req, " no extra read"}, served, nrd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req_o && !done_o && !error_o && !busy_o && data_o == 0, "R1 reset",
        {rd_req_o, done_o, error_o, busy_o}, 0);
    rst_n = 1;
    @(negedge clk);
    run_op("R3 prog first", 0, 8'hA5, 19'h00123, 0, 0, '{8'hA5, 8'hA5}, 0);
    run_op("R3 prog busy", 0, 8'h3C, 19'h7FFFF, 0, 1, '{8'hC4, 8'h80, 8'h12, 8'h3C}, 0);
    run_op("R4 erase", 1, 8'h00, 19'h40000, 0, 2, '{8'h40, 8'h04, 8'h80, 8'hFF}, 0);
    run_op("R5 recheck ok", 0, 8'h80, 19'h00010, 0, 0, '{8'h20, 8'h80, 8'h81}, 0);
    run_op("R6 recheck fail", 1, 8'hFF, 19'h00020, 0, 1, '{8'h20, 8'h60}, 0);
    run_op("R8 backstop", 0, 8'h80, 19'h00030, 3, 0, '{8'h00, 8'h01, 8'h02, 8'h80, 8'h80}, 0);
    run_op("R8 no limit", 0, 8'h80, 19'h00040, 0, 0,
           '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h99}, 0);
    run_op("R2 start ignored", 0, 8'hFF, 19'h00050, 0, 3, '{8'h7F, 8'h7F, 8'hFF, 8'hEE}, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule